// File: doc/BRIEF.md
# Direction-Controlled Serial Slave Port

This block is the host-facing serial port of a converter. An external host supplies a serial clock, an active-low select and a direction line. With the direction line low, the host writes an 8-bit control word, most significant bit first. With the direction line high, the host reads the 10-bit conversion result, most significant bit first. Every edge of the direction line marks the start or the end of a transfer.

All host pins are oversampled in the system clock domain through a two-stage synchronizer. Edges are detected on the synchronized copies. A parameter selects one of two pin arrangements:

- **Separate pins.** Data in and data out use their own pins, and the select pin gates all activity.
- **Shared pin.** One bidirectional data pin is used, and the select pin is ignored.

In both arrangements the data output comes with a tri-state enable. The converter side delivers a result together with a one-cycle new-data pulse. The port holds that result until one read consumes it. It presents the last complete control byte together with a one-cycle write strobe.

Top module: `ssp_port`

## Requirements
- R1: While and after reset, before any host activity, `sd_oe_o`, `sd_out_o`, `ctrl_wr_o` and `ctrl_byte_o` are all 0, and no result is held.
- R2: A read starts on a rising edge of `rdwr_i` while the port is selected. `sd_out_o` then shows bit 9 (the MSB) of the held result before any serial clock edge.
- R3: During a read, the first falling edge of `sclk_i` leaves the output unchanged. Each later falling edge advances one bit towards bit 0, MSB first. After bit 0, the output shifts zeros.
- R4: The host may end a read after only 8 bits. The 8 bits received are the top 8 bits of the result, and the read still consumes the result.
- R5: `sd_oe_o` is high from the start of a read until the first of two events: a falling edge of `rdwr_i`, or (separate-pin variant only) a rising edge of `cs_n_i`.
- R6: A `result_new_i` pulse stores `result_i`. Starting a read consumes the stored result, and a read with nothing stored shifts all zeros. A result that arrives in the same cycle as a read start is kept for the next read.
- R7: While `rdwr_i` is low and the port is selected, the first 8 rising edges of `sclk_i` shift `sd_in_i` in, MSB first, to form `ctrl_byte_o`. Further rising edges are ignored.
- R8: `ctrl_wr_o` pulses for exactly one cycle, in the same cycle that `ctrl_byte_o` takes the new byte, once the eighth bit has been received.
- R9: After 8 bits, no new write is possible until `rdwr_i` goes high and then low again. A falling edge of `rdwr_i` restarts the bit count.
- R10: With `SHARED_PIN=0`, a high `cs_n_i` makes the port ignore serial clock edges and read starts. With `SHARED_PIN=1`, `cs_n_i` has no effect.
- R11: Every host pin passes through two synchronizer stages and one edge stage. An effect caused by a pin change is visible at the outputs after the third rising edge of `clk` that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Host serial clock |
| cs_n_i | input | 1 | Active-low select (ignored in shared-pin variant) |
| rdwr_i | input | 1 | Direction: 1 read, 0 write |
| sd_in_i | input | 1 | Serial data from host (the data pin in shared-pin variant) |
| result_i | input | RES_W | Conversion result from converter side |
| result_new_i | input | 1 | One-cycle pulse: `result_i` is new |
| sd_out_o | output | 1 | Serial data to host |
| sd_oe_o | output | 1 | Tri-state enable for the data output |
| ctrl_byte_o | output | CTRL_W | Last complete control byte |
| ctrl_wr_o | output | 1 | One-cycle strobe on a new control byte |

## Verification
Host pin changes are driven on falling clock edges. Each such change affects the outputs three rising edges later, at the third falling edge after the drive, and one check pins this latency exactly. The bench runs a behavioural model that takes the host pins from two cycles of history, as the requirements state, and compares data, enable, byte and strobe at every falling edge.

The host-side tasks leave eight system clocks between serial clock edges. A sampled bit is therefore stable long before the bench reads it. The bench captures read bits just before each rising serial clock edge and checks transfer contents against constants. The cycle where a read start coincides with a new-data pulse is hit by counting exactly two rising edges after the direction change.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic sck;
    logic sel;
    logic rw;
    logic sdi;
  } ssp_pins_t;

  localparam int PIN_W = $bits(ssp_pins_t);
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise_i,
  input  logic              rw_fall_i,
  input  logic              rw_lvl_i,
  input  logic              sel_i,
  input  logic              sdi_i,
  output logic [CTRL_W-1:0] ctrl_byte_o,
  output logic              ctrl_wr_o
);
  localparam int CW = $clog2(CTRL_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(CTRL_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(CTRL_W - 1);

  logic [CW-1:0]     wcnt_q;
  logic [CTRL_W-1:0] sh_q;
  logic [CTRL_W-1:0] sh_next;

  assign sh_next = {sh_q[CTRL_W-2:0], sdi_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q      <= '0;
      sh_q        <= '0;
      ctrl_byte_o <= '0;
      ctrl_wr_o   <= 1'b0;
    end else begin
      ctrl_wr_o <= 1'b0;
      if (rw_fall_i) begin
        wcnt_q <= '0;
      end else if (!rw_lvl_i && sel_i && sck_rise_i && (wcnt_q < CNT_FULL)) begin
        sh_q   <= sh_next;
        wcnt_q <= wcnt_q + CW'(1);
        if (wcnt_q == CNT_LAST) begin
          ctrl_byte_o <= sh_next;
          ctrl_wr_o   <= 1'b1;
        end
      end
    end
  end

  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_o |-> $past(sck_rise_i));  // R8
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr_o |-> $stable(ctrl_byte_o));  // R7
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    wcnt_q <= CNT_FULL);  // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    rw_fall_i |=> (wcnt_q == '0));  // R9
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rw_rise_i,
  input  logic             rw_fall_i,
  input  logic             desel_i,
  input  logic             sck_fall_i,
  input  logic             sel_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             res_new_i,
  output logic             sd_out_o,
  output logic             sd_oe_o
);
  logic [RES_W-1:0] held_q;
  logic             full_q;
  logic [RES_W-1:0] shreg_q;
  logic             act_q;
  logic             skip_q;
  logic             start;

  assign start = rw_rise_i && sel_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      full_q <= 1'b0;
    end else if (res_new_i) begin
      held_q <= res_i;
      full_q <= 1'b1;
    end else if (start) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      act_q   <= 1'b0;
      skip_q  <= 1'b0;
    end else if (start) begin
      shreg_q <= full_q ? held_q : '0;
      act_q   <= 1'b1;
      skip_q  <= 1'b1;
    end else if (rw_fall_i || desel_i) begin
      shreg_q <= '0;
      act_q   <= 1'b0;
      skip_q  <= 1'b0;
    end else if (act_q && sel_i && sck_fall_i) begin
      if (skip_q) skip_q <= 1'b0;
      else        shreg_q <= {shreg_q[RES_W-2:0], 1'b0};
    end
  end

  assign sd_out_o = shreg_q[RES_W-1];
  assign sd_oe_o  = act_q;

  AST_READ_ARMS: assert property (@(posedge clk) disable iff (rst)
    start |=> sd_oe_o);  // R2
  AST_OE_RW_END: assert property (@(posedge clk) disable iff (rst)
    (rw_fall_i && !start) |=> !sd_oe_o);  // R5
  AST_OE_DESEL_END: assert property (@(posedge clk) disable iff (rst)
    (desel_i && !start) |=> !sd_oe_o);  // R5
  AST_CONSUME: assert property (@(posedge clk) disable iff (rst)
    (start && !res_new_i) |=> !full_q);  // R6
  AST_SKIP_FIRST: assert property (@(posedge clk) disable iff (rst)
    (act_q && skip_q && sel_i && sck_fall_i && !start && !rw_fall_i && !desel_i)
      |=> $stable(shreg_q));  // R3
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int CTRL_W      = 8,
  parameter bit SHARED_PIN  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              rdwr_i,
  input  logic              sd_in_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic              result_new_i,
  output logic              sd_out_o,
  output logic              sd_oe_o,
  output logic [CTRL_W-1:0] ctrl_byte_o,
  output logic              ctrl_wr_o
);
  logic [PIN_W-1:0] raw;
  logic [PIN_W-1:0] sync_q;
  ssp_pins_t        cur;
  logic [2:0]       prev_q;
  logic             sck_p, sel_p, rw_p;
  logic             sel, desel;
  logic             sck_rise, sck_fall, rw_rise, rw_fall;

  assign raw = {sclk_i, ~cs_n_i, rdwr_i, sd_in_i};

  ssp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw),
    .q   (sync_q)
  );

  assign cur = ssp_pins_t'(sync_q);

  always_ff @(posedge clk) begin
    prev_q <= {cur.sck, cur.sel, cur.rw};
  end

  assign {sck_p, sel_p, rw_p} = prev_q;

  generate
    if (SHARED_PIN) begin : g_shared
      assign sel   = 1'b1 | cur.sel;
      assign desel = 1'b0 & sel_p;
    end else begin : g_split
      assign sel   = cur.sel;
      assign desel = sel_p & ~cur.sel;
    end
  endgenerate

  assign sck_rise = cur.sck & ~sck_p;
  assign sck_fall = ~cur.sck & sck_p;
  assign rw_rise  = cur.rw & ~rw_p;
  assign rw_fall  = ~cur.rw & rw_p;

  ssp_rx #(.CTRL_W(CTRL_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .sck_rise_i  (sck_rise),
    .rw_fall_i   (rw_fall),
    .rw_lvl_i    (cur.rw),
    .sel_i       (sel),
    .sdi_i       (cur.sdi),
    .ctrl_byte_o (ctrl_byte_o),
    .ctrl_wr_o   (ctrl_wr_o)
  );

  ssp_tx #(.RES_W(RES_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .rw_rise_i  (rw_rise),
    .rw_fall_i  (rw_fall),
    .desel_i    (desel),
    .sck_fall_i (sck_fall),
    .sel_i      (sel),
    .res_i      (result_i),
    .res_new_i  (result_new_i),
    .sd_out_o   (sd_out_o),
    .sd_oe_o    (sd_oe_o)
  );

  AST_NO_DIR_CLASH: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_o |-> !sd_oe_o);  // R7
endmodule

// File: tb/test_ssp_port.sv
module test_ssp_port;
  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b1;
  logic       cs_n = 1'b1;
  logic       rdwr = 1'b0;
  logic       sdi = 1'b0;
  logic [9:0] result = '0;
  logic       result_new = 1'b0;

  logic       o_out [2];
  logic       o_oe  [2];
  logic [7:0] o_byte [2];
  logic       o_wr  [2];

  int n_chk = 0;
  int n_fail = 0;
  int sc [2] = '{0, 0};

  always #2 clk = ~clk;

  ssp_port #(.SHARED_PIN(1'b0)) i_ssp_port (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .rdwr_i(rdwr),
    .sd_in_i(sdi), .result_i(result), .result_new_i(result_new),
    .sd_out_o(o_out[0]), .sd_oe_o(o_oe[0]), .ctrl_byte_o(o_byte[0]), .ctrl_wr_o(o_wr[0]));

  ssp_port #(.SHARED_PIN(1'b1)) i_ssp_port_sh (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(1'b1), .rdwr_i(rdwr),
    .sd_in_i(sdi), .result_i(result), .result_new_i(result_new),
    .sd_out_o(o_out[1]), .sd_oe_o(o_oe[1]), .ctrl_byte_o(o_byte[1]), .ctrl_wr_o(o_wr[1]));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model: a pin change is acted on two samples later (R11).
  logic [3:0] h0 = 4'b1000, h1 = 4'b1000, h2 = 4'b1000, h3 = 4'b1000;
  int m_act [2], m_skip [2], m_data [2], m_full [2], m_held [2];
  int m_wcnt [2], m_wsh [2], m_byte [2], m_wr [2];

  always @(posedge clk) begin
    logic [3:0] c, p;
    logic sl, rr, rf, sr, sf, ds;
    h3 = h2; h2 = h1; h1 = h0; h0 = {sclk, ~cs_n, rdwr, sdi};
    c = h2; p = h3;
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_act[k] = 0; m_skip[k] = 0; m_data[k] = 0; m_full[k] = 0; m_held[k] = 0;
        m_wcnt[k] = 0; m_wsh[k] = 0; m_byte[k] = 0; m_wr[k] = 0;
      end else begin
        sl = (k == 1) ? 1'b1 : c[2];
        ds = (k == 0) && p[2] && !c[2];
        rr = c[1] && !p[1]; rf = !c[1] && p[1];
        sr = c[3] && !p[3]; sf = !c[3] && p[3];
        if (rr && sl) begin
          m_act[k] = 1; m_skip[k] = 1; m_data[k] = (m_full[k] != 0) ? m_held[k] : 0;
        end else if (rf || ds) begin
          m_act[k] = 0; m_skip[k] = 0; m_data[k] = 0;
        end else if ((m_act[k] != 0) && sl && sf) begin
          if (m_skip[k] != 0) m_skip[k] = 0;
          else m_data[k] = (m_data[k] * 2) % 1024;
        end
        if (result_new) begin m_held[k] = int'(result); m_full[k] = 1; end
        else if (rr && sl) m_full[k] = 0;
        m_wr[k] = 0;
        if (rf) m_wcnt[k] = 0;
        else if (!c[1] && sl && sr && m_wcnt[k] < 8) begin
          m_wsh[k] = (m_wsh[k] * 2 + int'(c[0])) % 256;
          m_wcnt[k]++;
          if (m_wcnt[k] == 8) begin m_byte[k] = m_wsh[k]; m_wr[k] = 1; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 2; k++) begin
        chk("R3 model sd_out", int'(o_out[k]), m_data[k] / 512);
        chk("R5 model sd_oe", int'(o_oe[k]), m_act[k]);
        chk("R7 model ctrl_byte", int'(o_byte[k]), m_byte[k]);
        chk("R8 model ctrl_wr", int'(o_wr[k]), m_wr[k]);
        if (o_wr[k]) sc[k]++;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b, input int extra);
    for (int i = 7; i >= -extra; i--) begin
      sclk = 1'b0;
      sdi = (i >= 0) ? b[i] : 1'b1;
      tick(HP);
      sclk = 1'b1;
      tick(HP);
    end
    sdi = 1'b0;
  endtask

  task automatic read_bits(input int n, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      tick(HP);
      got = {got[14:0], o_out[0]};
      sclk = 1'b1;
      tick(HP);
    end
  endtask

  task automatic pulse_result(input logic [9:0] v);
    result = v; result_new = 1'b1;
    tick(1);
    result_new = 1'b0;
  endtask

  initial begin
    logic [15:0] got;
    tick(6);
    chk("R1 reset oe", int'(o_oe[0]), 0);
    chk("R1 reset out", int'(o_out[0]), 0);
    chk("R1 reset byte", int'(o_byte[0]), 0);
    chk("R1 reset wr", int'(o_wr[0]), 0);
    rst = 1'b0;
    tick(5);

    cs_n = 1'b0; tick(4);
    write_byte(8'hA5, 2); tick(6);
    chk("R7 byte A5", int'(o_byte[0]), 8'hA5);
    chk("R8 one strobe", sc[0], 1);
    write_byte(8'h3C, 0); tick(6);
    chk("R9 no rewrite", int'(o_byte[0]), 8'hA5);

    rdwr = 1'b1; tick(HP);
    read_bits(10, got);
    chk("R6 empty read", int'(got[9:0]), 0);
    rdwr = 1'b0; tick(6);
    chk("R5 oe off after rdwr fall", int'(o_oe[0]), 0);
    write_byte(8'h3C, 0); tick(6);
    chk("R9 write after toggle", int'(o_byte[0]), 8'h3C);
    chk("R8 second strobe", sc[0], 2);

    pulse_result(10'h2D3); tick(2);
    rdwr = 1'b1; tick(2);
    chk("R11 oe not yet", int'(o_oe[0]), 0);
    tick(1);
    chk("R11 oe on third edge", int'(o_oe[0]), 1);
    chk("R2 first bit", int'(o_out[0]), 1);
    tick(HP);
    read_bits(12, got);
    chk("R3 ten bits then zeros", int'(got[11:0]), 12'hB4C);
    rdwr = 1'b0; tick(6);
    rdwr = 1'b1; tick(HP);
    read_bits(10, got);
    chk("R6 destructive reread", int'(got[9:0]), 0);
    rdwr = 1'b0; tick(HP);

    pulse_result(10'h155); tick(2);
    rdwr = 1'b1; tick(HP);
    read_bits(8, got);
    chk("R4 eight bits", int'(got[7:0]), 8'h55);
    cs_n = 1'b1; tick(6);
    chk("R5 oe off on cs_n rise", int'(o_oe[0]), 0);
    chk("R10 shared keeps oe", int'(o_oe[1]), 1);
    rdwr = 1'b0; tick(6);
    chk("R5 shared oe off", int'(o_oe[1]), 0);

    write_byte(8'hFF, 0); tick(6);
    chk("R10 deselected write ignored", int'(o_byte[0]), 8'h3C);
    chk("R10 shared ignores cs", int'(o_byte[1]), 8'hFF);
    rdwr = 1'b1; tick(6);
    chk("R10 deselected read not armed", int'(o_oe[0]), 0);
    rdwr = 1'b0; tick(6);

    cs_n = 1'b0; tick(4);
    rdwr = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    result = 10'h3A7; result_new = 1'b1;
    tick(1); result_new = 1'b0;
    tick(HP);
    read_bits(10, got);
    chk("R6 same-cycle read empty", int'(got[9:0]), 0);
    rdwr = 1'b0; tick(HP);
    rdwr = 1'b1; tick(HP);
    read_bits(10, got);
    chk("R6 same-cycle result kept", int'(got[9:0]), 10'h3A7);
    rdwr = 1'b0; tick(HP);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule